// File: doc/BRIEF.md
# Vector Gather Sequencer

This block executes one vector gather as a sequence of scalar memory reads. A gather starts with a base byte address, a vector of lane indices and a lane-enable mask. The sequencer splits the index vector into one index per lane. For each enabled lane it sends one read request to a simple memory port. Each returned word is written into that lane's slot of the destination vector. Disabled lanes are skipped: no read is sent for them, and their slot keeps the value it held before.

The memory port allows one outstanding request, and responses come back in order after a variable delay. Each lane may fall on a different line of memory, so the length of a gather depends on the latency of every read it makes. A one-cycle done pulse marks the cycle in which the destination vector is complete. A start request that arrives while a gather is in progress is ignored.

Top module: `vgather_seq`

## Requirements
- R1: After reset, busy, done and rd_req are 0 and every bit of result is 0.
- R2: The read address for lane j is base + idx_j * 8, taken modulo 2^ADDR_W. Here idx_j = idx_vec[j*IDX_W +: IDX_W] is an unsigned number. The base and the indices are the values captured at the accepted start.
- R3: Reads are issued for enabled lanes only, in ascending lane order. The first read is requested in the cycle after the start is accepted. Each later read is requested in the cycle after the response to the previous read.
- R4: rd_req lasts exactly one cycle per read. No new rd_req is raised until rsp_valid has returned the data for the current read.
- R5: A response word is written to result[j*DATA_W +: DATA_W] for the lane j whose read it answers.
- R6: A lane whose lane_mask bit is 0 causes no read, and its result slot keeps its earlier value. A gather with an all-zero mask makes no read and raises done two cycles after start is sampled.
- R7: done is high for exactly one cycle, the cycle after the final response is taken. In that cycle result is complete and busy is 0. busy is 1 in every cycle in between.
- R8: A start that is sampled while busy is 1 is ignored. The gather in progress keeps its captured base, indices and mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a gather when idle |
| base_addr | input | ADDR_W | Base byte address |
| idx_vec | input | LANES*IDX_W | Packed per-lane element indices |
| lane_mask | input | LANES | Lane enables, bit j for lane j |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Read request strobe |
| rd_addr | output | ADDR_W | Read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DATA_W | Read data word |
| result | output | LANES*DATA_W | Packed destination vector |

## Verification
The bench uses the default parameters: four lanes, 64-bit data, 16-bit indices and 32-bit addresses. With four lanes, all sixteen lane masks can be swept. Each mask is run with several index patterns, including the largest index and a base address that wraps. Memory latencies are varied from one to four cycles. These runs cover ascending-order skipping, merge behaviour for masked lanes, wrap of the address sum, and the empty gather. Some gathers also assert start in the middle of the gather, to check that the captured operands are held.

// File: rtl/vg_pkg.sv
package vg_pkg;
  typedef enum logic [1:0] {
    VG_IDLE  = 2'd0,
    VG_ISSUE = 2'd1,
    VG_WAIT  = 2'd2
  } vg_state_e;
endpackage

// File: rtl/vg_lane_pick.sv
module vg_lane_pick #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] grant,
  output logic [LW-1:0]    sel,
  output logic             any
);
  // lowest pending lane wins, giving ascending issue order
  always_comb begin
    sel   = '0;
    grant = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (pend[j]) sel = LW'(j);
    end
    any = |pend;
    if (any) grant[sel] = 1'b1;
  end

  always_comb begin
    p_grant_onehot_r3: assert ($onehot0(grant));
    p_grant_in_pend_r3: assert ((grant & ~pend) == '0);
  end
endmodule

// File: rtl/vg_addr_gen.sv
module vg_addr_gen #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int DATA_W = 64,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SHIFT = $clog2(DATA_W / 8)
) (
  input  logic [ADDR_W-1:0]      base,
  input  logic [LANES*IDX_W-1:0] idx_vec,
  input  logic [LW-1:0]          sel,
  output logic [ADDR_W-1:0]      addr
);
  function automatic logic [ADDR_W-1:0] elem_addr(
    input logic [ADDR_W-1:0] b,
    input logic [IDX_W-1:0]  i
  );
    logic [ADDR_W+SHIFT+IDX_W-1:0] off;
    off = {{(ADDR_W+SHIFT){1'b0}}, i} << SHIFT;
    return b + off[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] lane_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane_addr[g] = elem_addr(base, idx_vec[g*IDX_W +: IDX_W]);
  end

  assign addr = lane_addr[sel];
endmodule

// File: rtl/vg_pack.sv
module vg_pack #(
  parameter int LANES  = 4,
  parameter int DATA_W = 64,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_lane,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [LANES*DATA_W-1:0] result
);
  for (genvar g = 0; g < LANES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_lane == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   result[g*DATA_W +: DATA_W] <= '0;
      else if (hit) result[g*DATA_W +: DATA_W] <= wr_data;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(result));
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int DATA_W = 64,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic [LANES*IDX_W-1:0]  idx_vec,
  input  logic [LANES-1:0]        lane_mask,
  output logic                    busy,
  output logic                    done,
  output logic                    rd_req,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic                    rsp_valid,
  input  logic [DATA_W-1:0]       rsp_data,
  output logic [LANES*DATA_W-1:0] result
);
  import vg_pkg::*;

  vg_state_e              state_q;
  logic [ADDR_W-1:0]      base_q;
  logic [LANES*IDX_W-1:0] idx_q;
  logic [LANES-1:0]       pend_q;
  logic [LW-1:0]          cur_q;
  logic                   done_q;

  logic [LANES-1:0] grant;
  logic [LW-1:0]    sel;
  logic             any_pend;
  logic [LANES-1:0] cur_onehot;

  // named internal events
  logic accept_start, issue_fire, rsp_take, last_take, empty_finish;

  vg_lane_pick #(.LANES(LANES)) u_pick (
    .pend(pend_q), .grant(grant), .sel(sel), .any(any_pend)
  );

  vg_addr_gen #(.LANES(LANES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_addr (
    .base(base_q), .idx_vec(idx_q), .sel(sel), .addr(rd_addr)
  );

  vg_pack #(.LANES(LANES), .DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .wr_en(rsp_take), .wr_lane(cur_q),
    .wr_data(rsp_data), .result(result)
  );

  always_comb begin
    cur_onehot        = '0;
    cur_onehot[cur_q] = 1'b1;
  end

  assign accept_start = (state_q == VG_IDLE) && start;
  assign issue_fire   = (state_q == VG_ISSUE) && any_pend;
  assign empty_finish = (state_q == VG_ISSUE) && !any_pend;
  assign rsp_take     = (state_q == VG_WAIT) && rsp_valid;
  assign last_take    = rsp_take && ((pend_q & ~cur_onehot) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VG_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= empty_finish || last_take;
      case (state_q)
        VG_IDLE: if (accept_start) begin
          base_q  <= base_addr;
          idx_q   <= idx_vec;
          pend_q  <= lane_mask;
          state_q <= VG_ISSUE;
        end
        VG_ISSUE: begin
          if (issue_fire) begin
            cur_q   <= sel;
            state_q <= VG_WAIT;
          end else begin
            state_q <= VG_IDLE;
          end
        end
        VG_WAIT: if (rsp_take) begin
          pend_q  <= pend_q & ~cur_onehot;
          state_q <= last_take ? VG_IDLE : VG_ISSUE;
        end
        default: state_q <= VG_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != VG_IDLE);
  assign done   = done_q;
  assign rd_req = issue_fire;

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_no_req_in_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_req && !rsp_valid && !done) |=> !rd_req || $past(state_q == VG_ISSUE));
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q) && $stable(idx_q));
endmodule

// File: tb/vgather_seq_test.sv
module vgather_seq_test;
  localparam int LANES = 4, AW = 32, IW = 16, DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LANES*IW-1:0] idx_vec = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic busy, done, rd_req;
  logic [AW-1:0] rd_addr;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [LANES*DW-1:0] result;

  int total = 0, bad = 0, req_cnt = 0;
  bit finished = 0;
  logic [LANES*DW-1:0] exp_res = '0;

  always #5 clk = ~clk;

  vgather_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .idx_vec(idx_vec), .lane_mask(lane_mask), .busy(busy), .done(done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .result(result)
  );

  always @(negedge clk) if (rd_req === 1'b1) req_cnt++;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_3C3C, (~a) + 32'd7};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gather(input logic [AW-1:0] base, input logic [LANES*IW-1:0] idx,
                        input logic [LANES-1:0] mask, input int lat, input bit intrude);
    int start_reqs;
    @(negedge clk);
    base_addr = base; idx_vec = idx; lane_mask = mask; start = 1'b1;
    start_reqs = req_cnt;
    @(negedge clk);
    start = 1'b0; base_addr = ~base; idx_vec = ~idx; lane_mask = ~mask;
    if (mask == '0) begin
      chk(rd_req === 1'b0 && busy === 1'b1, "R6", {rd_req, busy}, 2'b01);
      @(negedge clk);
    end
    for (int j = 0; j < LANES; j++) begin
      if (mask[j]) begin
        logic [AW-1:0] ea;
        ea = base + (AW'(idx[j*IW +: IW]) << 3);
        chk(rd_req === 1'b1, "R3", rd_req, 1'b1);
        chk(rd_addr === ea, intrude ? "R8" : "R2", rd_addr, ea);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk(rd_req === 1'b0, "R4", rd_req, 1'b0);
          chk(done === 1'b0 && busy === 1'b1, "R7", {done, busy}, 2'b01);
          if (intrude) begin
            start = 1'b1; base_addr = base ^ 32'h0000_1000; lane_mask = '1;
          end
        end
        rsp_valid = 1'b1;
        rsp_data = mem_word(ea);
        exp_res[j*DW +: DW] = mem_word(ea);
        @(negedge clk);
        rsp_valid = 1'b0; start = 1'b0;
      end
    end
    chk(done === 1'b1 && busy === 1'b0, "R7", {done, busy}, 2'b10);
    chk(result === exp_res, "R5", result, exp_res);
    chk(req_cnt - start_reqs == $countones(mask), "R6", req_cnt - start_reqs, $countones(mask));
    @(negedge clk);
    chk(done === 1'b0, "R7", done, 1'b0);
    chk(result === exp_res, "R6", result, exp_res);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && rd_req === 1'b0, "R1",
        {busy, done, rd_req}, 3'b000);
    chk(result === '0, "R1", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 3; p++) begin
        logic [AW-1:0] b;
        logic [LANES*IW-1:0] ix;
        case (p)
          0: begin b = 32'h0000_1000 + AW'(m * 64);
               ix = {16'd3, 16'd2, 16'd1, 16'd0}; end
          1: begin b = 32'h8000_0008;
               ix = {16'd17, 16'd900, 16'd5, 16'd42}; end
          default: begin b = 32'hFFFF_FFF0;
               ix = {16'hFFFF, 16'd1, 16'h8000, 16'd2}; end
        endcase
        gather(b, ix, m[3:0], 1 + (m + p) % 4, p == 1);
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule